// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer controlled through a single 16-bit control word. Software keeps it alive by writing that word again. While the watchdog is armed, a write takes effect only if it carries a 7-bit key equal to the bitwise inverse of the key that was last accepted. A stray or runaway write that does not know the current key therefore cannot service the watchdog, reprogram it or stop it.

The counter moves down by one on each slow tick. The slow tick comes from an internal prescaler that divides the system clock by a parameter. The first time the count runs out, the block does not request a reset. It raises a non-maskable interrupt and reloads a short grace count, so an interrupt handler gets one last chance to service it. If the grace count also runs out, the block asserts a reset request. That request stays high until the block itself is reset; the logic that actually resets the system sits outside this block.

A status view is always available at the ports: the live count, whether the stored word has the watchdog armed, and whether the interrupt stage is active.

Top module: `keyed_watchdog`

## Requirements
- R1: The control word has three fields. Bits [15:9] hold the 7-bit key, bit 8 is the start bit (1 = armed and counting, 0 = stopped), and bits [7:0] hold the reload count.
- R2: While the stored start bit is 1, a write whose key is not the bitwise inverse of the stored key is ignored. It leaves `cnt_o`, `enabled_o`, `nmi_o` and the stored key unchanged.
- R3: While the stored start bit is 0, every write is accepted, whatever key it carries.
- R4: An accepted write stores the whole word. One cycle later, `cnt_o` shows the count field, or 256 when the count field is 0.
- R5: After an accepted write with the start bit set, the counter runs. After an accepted write with the start bit clear, `cnt_o` holds its value indefinitely and `enabled_o` is 0.
- R6: While running, `cnt_o` decreases by one every `TICK_DIV` clocks. The first decrement comes `TICK_DIV` clocks after the accepting write.
- R7: A tick that arrives while the count is 1 and `nmi_o` is low is the first expiry. It sets `nmi_o` and reloads the count with `GRACE` (default 10).
- R8: A tick that arrives while the count is 1 and `nmi_o` is already high is the second expiry. It sets `rst_req_o` and stops the counter at 0. `rst_req_o` then stays high until `rst`, even if further writes are accepted.
- R9: An accepted write clears `nmi_o`, so the next expiry counts as a first expiry again.
- R10: Synchronous reset clears the stored word, the count, `nmi_o` and `rst_req_o`. The watchdog is then disarmed, so the next write is accepted with any key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control-word write strobe, one cycle per write |
| wr_data | input | 16 | Control word: key [15:9], start [8], count [7:0] |
| cnt_o | output | 9 | Live count (0 to 256) |
| enabled_o | output | 1 | Start bit of the stored control word |
| nmi_o | output | 1 | Non-maskable interrupt; high in the grace stage |
| rst_req_o | output | 1 | Sticky system reset request |

## Verification
The hardest state to reach is the second expiry. The bench must first arm the counter, then let a complete count and a complete grace count run out with no accepted write in between. It must also land its samples exactly on the ticks where `nmi_o` and `rst_req_o` change. The bench reaches this by shrinking `TICK_DIV` to 4 and counting clock edges from the accepting write: first expiry at 4·N edges, reset request 40 edges after that. It samples one edge before and one edge on each of those points. It also checks the key chain with each key derived from the previous accepted one. This shows that a rejected write leaves no trace, and that a reset clears the stored key.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int KEY_BITS   = 7;
    localparam int LOAD_BITS  = 8;
    localparam int WORD_BITS  = KEY_BITS + 1 + LOAD_BITS;
    localparam int CNT_BITS   = LOAD_BITS + 1;
    localparam int FULL_COUNT = 1 << LOAD_BITS;

    typedef struct packed {
        logic [KEY_BITS-1:0]  key;
        logic                 start;
        logic [LOAD_BITS-1:0] load;
    } wdg_word_t;

    typedef enum logic [1:0] {
        EXP_NONE  = 2'd0,
        EXP_STEP  = 2'd1,
        EXP_NMI   = 2'd2,
        EXP_RESET = 2'd3
    } wdg_event_e;

    function automatic logic [CNT_BITS-1:0] reload_of(input logic [LOAD_BITS-1:0] f);
        if (f == '0)
            return CNT_BITS'(FULL_COUNT);
        return {1'b0, f};
    endfunction

    function automatic logic key_matches(input logic [KEY_BITS-1:0] held,
                                         input logic [KEY_BITS-1:0] offered);
        return offered == ~held;
    endfunction

    function automatic wdg_event_e classify(input logic                running,
                                            input logic                tick,
                                            input logic [CNT_BITS-1:0] cnt,
                                            input logic                in_grace);
        if (!(running && tick))
            return EXP_NONE;
        if (cnt > CNT_BITS'(1))
            return EXP_STEP;
        if (!in_grace)
            return EXP_NMI;
        return EXP_RESET;
    endfunction

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int TICK_DIV = 65790
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] phase_q;

    assign tick_o = run_i && (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            phase_q <= '0;
        else if (run_i)
            phase_q <= tick_o ? '0 : phase_q + PW'(1);
    end

    // R6: the phase never passes the divider limit
    p_phase_bound_r6: assert property (@(posedge clk) disable iff (rst)
        phase_q <= LAST);

    // R6: a stopped prescaler keeps its phase unless cleared
    p_phase_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !clr_i) |=> $stable(phase_q));

endmodule

// File: rtl/wdg_keygate.sv
module wdg_keygate
    import wdg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [WORD_BITS-1:0] wr_data,
    output logic                 load_o,
    output wdg_word_t            word_o,
    output logic                 armed_o
);
    wdg_word_t held_q;
    wdg_word_t offer;

    assign offer   = wdg_word_t'(wr_data);
    assign armed_o = held_q.start;
    assign word_o  = offer;
    assign load_o  = wr_en && (!held_q.start || key_matches(held_q.key, offer.key));

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= '0;
        else if (load_o)
            held_q <= offer;
    end

    // R2: a wrong key while armed leaves the stored word untouched
    p_reject_keeps_word_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && held_q.start && (offer.key != ~held_q.key)) |=> $stable(held_q));

    // R3: while disarmed any written word is taken as-is
    p_open_takes_word_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !held_q.start) |=> (held_q == $past(offer)));

endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown
    import wdg_pkg::*;
#(
    parameter int GRACE = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  wdg_word_t           word_i,
    input  logic                tick_i,
    output logic                run_o,
    output logic [CNT_BITS-1:0] cnt_o,
    output logic                nmi_o,
    output logic                rst_req_o
);
    localparam logic [CNT_BITS-1:0] GRACE_CNT = CNT_BITS'(GRACE);

    logic [CNT_BITS-1:0] cnt_q;
    logic                run_q;
    logic                nmi_q;
    logic                req_q;
    wdg_event_e          ev;

    assign ev = classify(run_q, tick_i, cnt_q, nmi_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            nmi_q <= 1'b0;
            req_q <= 1'b0;
        end else if (load_i) begin
            cnt_q <= reload_of(word_i.load);
            run_q <= word_i.start;
            nmi_q <= 1'b0;
        end else begin
            unique case (ev)
                EXP_STEP:  cnt_q <= cnt_q - CNT_BITS'(1);
                EXP_NMI: begin
                    nmi_q <= 1'b1;
                    cnt_q <= GRACE_CNT;
                end
                EXP_RESET: begin
                    req_q <= 1'b1;
                    run_q <= 1'b0;
                    cnt_q <= '0;
                end
                default: ;
            endcase
        end
    end

    assign run_o     = run_q;
    assign cnt_o     = cnt_q;
    assign nmi_o     = nmi_q;
    assign rst_req_o = req_q;

    // R4: a load with a zero count field gives the full count
    p_zero_is_full_r4: assert property (@(posedge clk) disable iff (rst)
        (load_i && word_i.load == '0) |=> (cnt_q == CNT_BITS'(FULL_COUNT)));

    // R4: the count never exceeds the full count
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_BITS'(FULL_COUNT));

    // R6: without a tick or a load the count stays put
    p_no_tick_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !load_i) |=> $stable(cnt_q));

    // R7: the interrupt rises only on a tick at count 1
    p_nmi_on_expiry_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_q) |-> ($past(cnt_q) == CNT_BITS'(1) && $past(tick_i)));

    // R8: the reset request needs the interrupt stage first
    p_req_after_nmi_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(req_q) |-> $past(nmi_q));

    // R8: the reset request is sticky
    p_req_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        req_q |=> req_q);

    // R9: an accepted write drops the interrupt
    p_load_clears_nmi_r9: assert property (@(posedge clk) disable iff (rst)
        load_i |=> !nmi_q);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdg_pkg::*;
#(
    parameter int TICK_DIV = 65790,
    parameter int GRACE    = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [WORD_BITS-1:0] wr_data,
    output logic [CNT_BITS-1:0]  cnt_o,
    output logic                 enabled_o,
    output logic                 nmi_o,
    output logic                 rst_req_o
);
    logic      load;
    wdg_word_t word;
    logic      run;
    logic      tick;

    wdg_keygate u_gate (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .load_o  (load),
        .word_o  (word),
        .armed_o (enabled_o)
    );

    wdg_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (load),
        .run_i  (run),
        .tick_o (tick)
    );

    wdg_countdown #(.GRACE(GRACE)) u_count (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .word_i    (word),
        .tick_i    (tick),
        .run_o     (run),
        .cnt_o     (cnt_o),
        .nmi_o     (nmi_o),
        .rst_req_o (rst_req_o)
    );

    // R5: a disarmed watchdog never counts
    p_disarmed_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!enabled_o && !wr_en) |=> $stable(cnt_o));

endmodule

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int NVEC       = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [8:0]  cnt_o;
    logic        enabled_o;
    logic        nmi_o;
    logic        rst_req_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_watchdog #(.TICK_DIV(DIV), .GRACE(10)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cnt_o     (cnt_o),
        .enabled_o (enabled_o),
        .nmi_o     (nmi_o),
        .rst_req_o (rst_req_o)
    );

    // {word[15:0], expected count[8:0], expected enabled}
    localparam logic [25:0] VEC [NVEC] = '{
        {16'h2A05, 9'd5,   1'b0},  // R3 disarmed, key 0x15 stopped
        {16'h6700, 9'd256, 1'b1},  // R3 R4 key 0x33 start, count 0 -> 256
        {16'h6707, 9'd256, 1'b1},  // R2 same key again: rejected
        {16'h9914, 9'd20,  1'b1},  // R1 key 0x4C = ~0x33 accepted
        {16'h9930, 9'd20,  1'b1},  // R2 key 0x4C repeated: rejected
        {16'h6609, 9'd9,   1'b0},  // R5 key 0x33, start clear
        {16'h0103, 9'd3,   1'b1},  // R3 disarmed again, key 0x00
        {16'hFFC8, 9'd200, 1'b1},  // R1 key 0x7F = ~0x00
        {16'hFD11, 9'd200, 1'b1},  // R2 key 0x7E off by one bit
        {16'h0101, 9'd1,   1'b1}   // R1 key 0x00 = ~0x7F
    };

    function automatic logic [15:0] mkword(input logic [6:0] k, input logic s,
                                           input logic [7:0] c);
        return {k, s, c};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wait_edges(2);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL timeout all-requirements actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_edges(3);
        rst = 1'b0;

        // R10 reset state
        do_reset();
        check("R10 cnt after reset", cnt_o, 0);
        check("R10 enabled after reset", enabled_o, 0);
        check("R10 nmi after reset", nmi_o, 0);
        check("R10 rst_req after reset", rst_req_o, 0);

        // vector table: key chain, rejection, zero count
        for (int i = 0; i < NVEC; i++) begin
            write_word(VEC[i][25:10]);
            check($sformatf("R1/R2/R3/R4 vec%0d cnt", i), cnt_o, int'(VEC[i][9:1]));
            check($sformatf("R2/R5 vec%0d enabled", i), enabled_o, int'(VEC[i][0]));
            check($sformatf("R2 vec%0d nmi", i), nmi_o, 0);
        end

        // R6 R7 R8: full escalation from count 3
        do_reset();
        write_word(mkword(7'h2A, 1'b1, 8'd3));
        check("R4 load 3", cnt_o, 3);
        wait_edges(DIV - 1);
        check("R6 before first tick", cnt_o, 3);
        wait_edges(1);
        check("R6 first tick", cnt_o, 2);
        wait_edges(2 * DIV - 1);
        check("R6 last count", cnt_o, 1);
        check("R7 no nmi yet", nmi_o, 0);
        wait_edges(1);
        check("R7 nmi raised", nmi_o, 1);
        check("R7 grace reload", cnt_o, 10);
        check("R7 no reset yet", rst_req_o, 0);
        wait_edges(10 * DIV - 1);
        check("R8 grace end count", cnt_o, 1);
        check("R8 no req before second expiry", rst_req_o, 0);
        wait_edges(1);
        check("R8 req asserted", rst_req_o, 1);
        check("R8 counter parked", cnt_o, 0);
        wait_edges(20);
        check("R8 req holds", rst_req_o, 1);
        check("R8 still parked", cnt_o, 0);
        write_word(mkword(7'h55, 1'b1, 8'd5));
        check("R9 service clears nmi", nmi_o, 0);
        check("R8 req sticky over write", rst_req_o, 1);
        check("R4 service reload", cnt_o, 5);

        // R9: service in grace stage resets escalation history
        do_reset();
        write_word(mkword(7'h11, 1'b1, 8'd2));
        wait_edges(2 * DIV);
        check("R7 nmi after short count", nmi_o, 1);
        write_word(mkword(7'h6E, 1'b1, 8'd4));
        check("R9 nmi cleared", nmi_o, 0);
        check("R9 reload 4", cnt_o, 4);
        wait_edges(4 * DIV);
        check("R9 expiry again is first stage", nmi_o, 1);
        check("R9 no reset request", rst_req_o, 0);
        check("R9 grace count", cnt_o, 10);

        // R5: stop holds count
        do_reset();
        write_word(mkword(7'h05, 1'b1, 8'd50));
        wait_edges(2 * DIV);
        check("R6 two ticks", cnt_o, 48);
        write_word(mkword(7'h7A, 1'b0, 8'd30));
        check("R5 stopped load", cnt_o, 30);
        check("R5 enabled low", enabled_o, 0);
        wait_edges(40);
        check("R5 count held", cnt_o, 30);
        check("R5 no nmi while stopped", nmi_o, 0);

        // R10: reset forgets stored key
        do_reset();
        write_word(mkword(7'h40, 1'b1, 8'd9));
        do_reset();
        write_word(mkword(7'h40, 1'b1, 8'd7));
        check("R10 key forgotten after reset", cnt_o, 7);
        write_word(mkword(7'h40, 1'b1, 8'd8));
        check("R2 wrong key after rearm", cnt_o, 7);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule